// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block owns the five active-low control lines of each general-purpose IO channel. Pin-mux or buffer settings can then be rewritten behind a frozen pad, and no glitch reaches the board. A requester names a channel and a direction, freeze or thaw. The block then walks that channel's lines through a fixed ordered set of steps. Consecutive steps are spaced by a minimum hold time, which the block converts from nanoseconds into clock cycles. Thawing releases the lines in the opposite order to freezing.

Only one sequence runs at a time. The block shows a busy flag while a sequence is in progress and a frozen/thawed flag per channel. Each request receives a one-cycle acknowledge or a one-cycle error. The block also drives a freeze-source select, which moves to software control once a request has been accepted.

Top module: `iofrz_seq`

## Requirements
- R1: After synchronous reset all control lines are low (every channel frozen), every `chan_frozen` bit is 1, `busy`, `req_ack` and `req_err` are 0, and `src_sel` is 1 (hardware control).
- R2: Channel i uses bits `io_ctrl[5i+4:5i]`, with slew enable at bit 4, weak pull-up at bit 3, tristate at bit 2, bus-hold at bit 1 and config-done at bit 0. An accepted freeze clears bits 4, 3 and 2 at the accepting clock edge. It clears bits 1 and 0 a gap later.
- R3: An accepted thaw sets bits 1 and 0 at the accepting edge. It sets bits 3 and 2 one gap later and sets bit 4 one further gap later.
- R4: The gap is ceil(MIN_GAP_NS*CLK_MHZ/1000) clock cycles, with a minimum of 1. With the default values of 20 ns and 250 MHz the gap is 5 cycles, and no step fires earlier than that.
- R5: An accepted request gives `req_ack` high for exactly the one cycle after the accepting edge. From that edge onward, `src_sel` reads 0 (software control).
- R6: A request whose channel index is NUM_CHAN or above is rejected. `req_err` goes high for one cycle, no acknowledge is given, and `io_ctrl`, `busy`, `chan_frozen` and `src_sel` do not change.
- R7: `busy` rises at the accepting edge and falls at the edge of the last step. A request presented while `busy` is high is refused. It gets no acknowledge and no error, and it has no effect on any output.
- R8: A channel's `chan_frozen` flag changes at the edge of the last step: it becomes 1 after a freeze and 0 after a thaw.
- R9: A freeze request to a channel that is already frozen, or a thaw request to one already thawed, runs the full sequence with the same busy time. It leaves the lines and the flag unchanged.
- R10: A sequence changes only the lines of the addressed channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_thaw | input | 1 | Direction: 0 freeze, 1 thaw |
| req_chan | input | IDX_W (3) | Channel index |
| req_ack | output | 1 | One-cycle pulse: request accepted |
| req_err | output | 1 | One-cycle pulse: invalid channel index |
| busy | output | 1 | A sequence is in progress |
| src_sel | output | 1 | Freeze-source select: 0 software, 1 hardware |
| chan_frozen | output | NUM_CHAN (3) | Per-channel status, 1 = frozen |
| io_ctrl | output | 5*NUM_CHAN (15) | Active-low control lines, five per channel |

## Verification
A step counter that advances at the wrong time shows up as a line moving one or more cycles away from its gap boundary. Sampling on the cycle just before each boundary as well as on the boundary itself catches this at the first misplaced step. A wrong mask or a reversed order leaves a channel with its slew line released while tristate or bus-hold is still held. That is visible at the ports as soon as the faulty step lands. A stale direction or channel register shows up when the sequence completes: a flag or line pattern belongs to the wrong channel, or `busy` stays high past the last step.

// File: rtl/iofrz_pkg.sv
// Shared types and step tables for the IO freeze/thaw sequencer.
// Assumes five active-low control lines per channel at fixed bit positions.
package iofrz_pkg;

    localparam int CTL_W  = 5;
    localparam int B_SLEW = 4;
    localparam int B_PULL = 3;
    localparam int B_TRI  = 2;
    localparam int B_HOLD = 1;
    localparam int B_DONE = 0;

    typedef logic [CTL_W-1:0] ctl_t;
    typedef logic [1:0]       step_t;

    typedef enum logic {
        OP_FREEZE = 1'b0,
        OP_THAW   = 1'b1
    } op_e;

    // Lines touched by step n of a sequence (cleared on freeze, set on thaw)
    function automatic ctl_t step_mask(op_e op, step_t n);
        ctl_t m;
        m = '0;
        if (op == OP_FREEZE) begin
            case (n)
                2'd0: begin m[B_SLEW] = 1'b1; m[B_PULL] = 1'b1; m[B_TRI] = 1'b1; end
                2'd1: begin m[B_HOLD] = 1'b1; m[B_DONE] = 1'b1; end
                default: m = '0;
            endcase
        end else begin
            case (n)
                2'd0: begin m[B_HOLD] = 1'b1; m[B_DONE] = 1'b1; end
                2'd1: begin m[B_PULL] = 1'b1; m[B_TRI] = 1'b1; end
                2'd2: m[B_SLEW] = 1'b1;
                default: m = '0;
            endcase
        end
        return m;
    endfunction

    // Index of the final step for a direction
    function automatic step_t last_step(op_e op);
        return (op == OP_FREEZE) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/iofrz_gap_timer.sv
// Down-counter that spaces consecutive steps by GAP_CYC cycles.
// Assumes load is pulsed on each step that is not the last; expired is high
// once GAP_CYC-1 decrements have elapsed (and while idle).
module iofrz_gap_timer #(
    parameter int GAP_CYC = 5,
    parameter int CNT_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on a step, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/iofrz_step_ctrl.sv
// Request acceptance and step sequencing for one sequence at a time.
// Assumes the gap timer reports expiry; emits a step strobe with its number,
// direction and channel, the first step in the same cycle as acceptance.
module iofrz_step_ctrl
    import iofrz_pkg::*;
#(
    parameter int NUM_CHAN = 3,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_thaw,
    input  logic [IDX_W-1:0] req_chan,
    input  logic             gap_expired,
    output logic             busy,
    output logic             req_ack,
    output logic             req_err,
    output logic             src_sel,
    output logic             tmr_load,
    output logic             step_fire,
    output op_e              step_op,
    output step_t            step_num,
    output logic [IDX_W-1:0] step_chan,
    output logic             step_last
);

    localparam logic [IDX_W-1:0] CHAN_LIM = IDX_W'(NUM_CHAN);

    logic             busy_q;
    logic             ack_q;
    logic             err_q;
    logic             src_q;
    op_e              op_q;
    step_t            num_q;
    logic [IDX_W-1:0] chan_q;

    logic accept;
    logic reject;
    logic advance;

    // Classify an incoming request against busy state and index range
    always_comb begin
        accept  = req_valid && !busy_q && (req_chan < CHAN_LIM);
        reject  = req_valid && !busy_q && !(req_chan < CHAN_LIM);
        advance = busy_q && gap_expired;
    end

    // Describe the step that fires this cycle, if any
    always_comb begin
        step_fire = accept || advance;
        step_op   = accept ? op_e'(req_thaw) : op_q;
        step_num  = accept ? 2'd0 : step_t'(num_q + 2'd1);
        step_chan = accept ? req_chan : chan_q;
        step_last = (step_num == last_step(step_op));
        tmr_load  = step_fire && !step_last;
    end

    // Sequence state: busy flag, current step, latched direction and channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            num_q  <= 2'd0;
            op_q   <= OP_FREEZE;
            chan_q <= '0;
        end else begin
            if (step_fire) begin
                busy_q <= !step_last;
                num_q  <= step_num;
            end
            if (accept) begin
                op_q   <= op_e'(req_thaw);
                chan_q <= req_chan;
            end
        end
    end

    // Handshake pulses and freeze-source select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
            src_q <= 1'b1;
        end else begin
            ack_q <= accept;
            err_q <= reject;
            if (accept) begin
                src_q <= 1'b0;
            end
        end
    end

    assign busy    = busy_q;
    assign req_ack = ack_q;
    assign req_err = err_q;
    assign src_sel = src_q;

endmodule

// File: rtl/iofrz_chan_bank.sv
// Per-channel control-line and status registers.
// Assumes at most one step strobe per cycle; only the addressed channel
// applies the step mask, clearing lines on freeze and setting them on thaw.
module iofrz_chan_bank
    import iofrz_pkg::*;
#(
    parameter int NUM_CHAN = 3,
    parameter int IDX_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_fire,
    input  op_e                       step_op,
    input  step_t                     step_num,
    input  logic [IDX_W-1:0]          step_chan,
    input  logic                      step_last,
    output logic [NUM_CHAN*CTL_W-1:0] io_ctrl,
    output logic [NUM_CHAN-1:0]       chan_frozen
);

    ctl_t mask;

    assign mask = step_mask(step_op, step_num);

    for (genvar i = 0; i < NUM_CHAN; i++) begin : g_ch
        logic hit;
        ctl_t ctl_q;
        logic frz_q;

        assign hit = step_fire && (step_chan == IDX_W'(i));

        // Apply the step mask and update status on the final step
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q <= '0;
                frz_q <= 1'b1;
            end else if (hit) begin
                if (step_op == OP_THAW) begin
                    ctl_q <= ctl_q | mask;
                end else begin
                    ctl_q <= ctl_q & ~mask;
                end
                if (step_last) begin
                    frz_q <= (step_op == OP_FREEZE);
                end
            end
        end

        assign io_ctrl[i*CTL_W +: CTL_W] = ctl_q;
        assign chan_frozen[i]            = frz_q;
    end

endmodule

// File: rtl/iofrz_seq.sv
// IO bank freeze/thaw sequencer top level.
// Converts the minimum step spacing from ns to cycles (rounded up), accepts
// one request at a time and drives five active-low lines per channel.
module iofrz_seq
    import iofrz_pkg::*;
#(
    parameter int NUM_CHAN   = 3,
    parameter int IDX_W      = 3,
    parameter int CLK_MHZ    = 250,
    parameter int MIN_GAP_NS = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_thaw,
    input  logic [IDX_W-1:0]          req_chan,
    output logic                      req_ack,
    output logic                      req_err,
    output logic                      busy,
    output logic                      src_sel,
    output logic [NUM_CHAN-1:0]       chan_frozen,
    output logic [NUM_CHAN*CTL_W-1:0] io_ctrl
);

    localparam int GAP_RAW = (MIN_GAP_NS * CLK_MHZ + 999) / 1000;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int CNT_W   = $clog2(GAP_CYC + 1);

    logic             gap_expired;
    logic             tmr_load;
    logic             step_fire;
    op_e              step_op;
    step_t            step_num;
    logic [IDX_W-1:0] step_chan;
    logic             step_last;

    iofrz_step_ctrl #(
        .NUM_CHAN (NUM_CHAN),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_thaw    (req_thaw),
        .req_chan    (req_chan),
        .gap_expired (gap_expired),
        .busy        (busy),
        .req_ack     (req_ack),
        .req_err     (req_err),
        .src_sel     (src_sel),
        .tmr_load    (tmr_load),
        .step_fire   (step_fire),
        .step_op     (step_op),
        .step_num    (step_num),
        .step_chan   (step_chan),
        .step_last   (step_last)
    );

    iofrz_gap_timer #(
        .GAP_CYC (GAP_CYC),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (gap_expired)
    );

    iofrz_chan_bank #(
        .NUM_CHAN (NUM_CHAN),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_fire   (step_fire),
        .step_op     (step_op),
        .step_num    (step_num),
        .step_chan   (step_chan),
        .step_last   (step_last),
        .io_ctrl     (io_ctrl),
        .chan_frozen (chan_frozen)
    );

endmodule

// File: rtl/iofrz_seq_chk.sv
// Port-level protocol and ordering checks for iofrz_seq, bound to every
// instance. Assumes the same gap conversion as the design's parameters.
module iofrz_seq_chk #(
    parameter int NUM_CHAN   = 3,
    parameter int IDX_W      = 3,
    parameter int CLK_MHZ    = 250,
    parameter int MIN_GAP_NS = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_thaw,
    input logic [IDX_W-1:0]      req_chan,
    input logic                  req_ack,
    input logic                  req_err,
    input logic                  busy,
    input logic                  src_sel,
    input logic [NUM_CHAN-1:0]   chan_frozen,
    input logic [NUM_CHAN*5-1:0] io_ctrl
);

    localparam int GAP_RAW = (MIN_GAP_NS * CLK_MHZ + 999) / 1000;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int CW      = $clog2(GAP_CYC + 2) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic [NUM_CHAN*5-1:0] prev_q;
    logic [CW-1:0]         since_q;
    logic [NUM_CHAN-1:0]   chg;

    // Track the previous line vector and cycles since the last change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            since_q <= CMAX;
        end else begin
            prev_q  <= io_ctrl;
            since_q <= (io_ctrl != prev_q) ? CW'(1) :
                       ((since_q == CMAX) ? since_q : since_q + 1'b1);
        end
    end

    for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chg
        assign chg[i] = (io_ctrl[i*5 +: 5] != prev_q[i*5 +: 5]);

        // R3: slew is released only after pull-up and tristate
        p_slew_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
            io_ctrl[i*5+4] |-> (io_ctrl[i*5+3] && io_ctrl[i*5+2]));

        // R2: pull-up/tristate released only while hold and done are released
        p_hold_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (io_ctrl[i*5+3] || io_ctrl[i*5+2]) |-> (io_ctrl[i*5+1] && io_ctrl[i*5+0]));

        // R8: when idle, lines match the status flag
        p_idle_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |-> (chan_frozen[i] ? (io_ctrl[i*5 +: 5] == 5'b00000)
                                      : (io_ctrl[i*5 +: 5] == 5'b11111)));
    end

    // R4: a change not caused by acceptance is at least a gap after the last one
    p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_ctrl != prev_q) && !req_ack) |-> (since_q >= CW'(GAP_CYC)));

    // R10: at most one channel's lines change per cycle
    p_one_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg));

    // R2: a single edge never sets and clears lines together
    p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !((|(io_ctrl & ~prev_q)) && (|(~io_ctrl & prev_q))));

    // R5: acceptance implies software source and busy
    p_ack_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (!src_sel && busy));

    // R6: an error pulse leaves lines and busy untouched and excludes ack
    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!req_ack && (io_ctrl == prev_q) && !busy));

    // R7: a request while busy gets neither ack nor error
    p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> (!req_ack && !req_err));

endmodule

bind iofrz_seq iofrz_seq_chk #(
    .NUM_CHAN   (NUM_CHAN),
    .IDX_W      (IDX_W),
    .CLK_MHZ    (CLK_MHZ),
    .MIN_GAP_NS (MIN_GAP_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_thaw    (req_thaw),
    .req_chan    (req_chan),
    .req_ack     (req_ack),
    .req_err     (req_err),
    .busy        (busy),
    .src_sel     (src_sel),
    .chan_frozen (chan_frozen),
    .io_ctrl     (io_ctrl)
);

// File: tb/iofrz_seq_bench.sv
// Scoreboard bench: request tasks push expected per-cycle snapshots into a
// queue; a negedge monitor pops and compares them against the ports.
module iofrz_seq_bench;

    localparam int NCH = 3;
    localparam int W   = NCH * 5;
    localparam int G   = (20 * 250 + 999) / 1000;

    typedef struct {
        int          cyc;
        logic [W-1:0] ctrl;
        logic        busy;
        logic        ack;
        logic        err;
        logic [NCH-1:0] frz;
        logic        src;
        string       tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_thaw = 1'b0;
    logic [2:0]     req_chan = '0;
    logic           req_ack;
    logic           req_err;
    logic           busy;
    logic           src_sel;
    logic [NCH-1:0] chan_frozen;
    logic [W-1:0]   io_ctrl;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    exp_t q[$];

    logic [W-1:0]   m_ctrl = '0;
    logic [NCH-1:0] m_frz = '1;
    logic           m_src = 1'b1;

    iofrz_seq u_iofrz_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_thaw    (req_thaw),
        .req_chan    (req_chan),
        .req_ack     (req_ack),
        .req_err     (req_err),
        .busy        (busy),
        .src_sel     (src_sel),
        .chan_frozen (chan_frozen),
        .io_ctrl     (io_ctrl)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int c, input logic [W-1:0] ct, input logic b,
                        input logic a, input logic e, input logic [NCH-1:0] f,
                        input logic s, input string t);
        exp_t x;
        x.cyc = c; x.ctrl = ct; x.busy = b; x.ack = a; x.err = e;
        x.frz = f; x.src = s; x.tag = t;
        q.push_back(x);
    endtask

    // Monitor: compare every expected snapshot due by this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t x;
            x = q.pop_front();
            n_chk++;
            if (io_ctrl !== x.ctrl || busy !== x.busy || req_ack !== x.ack ||
                req_err !== x.err || chan_frozen !== x.frz || src_sel !== x.src) begin
                n_err++;
                $display("FAIL %s cyc=%0d actual ctrl=%h busy=%b ack=%b err=%b frz=%b src=%b expected ctrl=%h busy=%b ack=%b err=%b frz=%b src=%b",
                         x.tag, cyc, io_ctrl, busy, req_ack, req_err, chan_frozen, src_sel,
                         x.ctrl, x.busy, x.ack, x.err, x.frz, x.src);
            end
        end
    end

    // Run one accepted sequence; optionally poke another request while busy
    task automatic run_seq(input bit thaw, input int ch, input string tag, input bit poke);
        int c0;
        int last;
        logic [W-1:0] s0, s1, s2;
        @(negedge clk);
        req_valid = 1'b1; req_thaw = thaw; req_chan = 3'(ch);
        @(posedge clk); #1;
        c0 = cyc;
        m_src = 1'b0;
        if (!thaw) begin
            s0 = m_ctrl & ~(W'(5'b11100) << (5 * ch));
            s1 = s0 & ~(W'(5'b00011) << (5 * ch));
            push(c0,     s0, 1, 1, 0, m_frz, 0, {"R2/R5 freeze step0 ", tag});
            push(c0 + 1, s0, 1, 0, 0, m_frz, 0, {"R7/R10 hold ", tag});
            push(c0 + G - 1, s0, 1, 0, 0, m_frz, 0, {"R4 no early step ", tag});
            m_frz[ch] = 1'b1;
            push(c0 + G, s1, 0, 0, 0, m_frz, 0, {"R2/R8 freeze last ", tag});
            m_ctrl = s1;
            last = c0 + G;
        end else begin
            s0 = m_ctrl | (W'(5'b00011) << (5 * ch));
            s1 = s0 | (W'(5'b01100) << (5 * ch));
            s2 = s1 | (W'(5'b10000) << (5 * ch));
            push(c0,     s0, 1, 1, 0, m_frz, 0, {"R3/R5 thaw step0 ", tag});
            push(c0 + 1, s0, 1, 0, 0, m_frz, 0, {"R7/R10 hold ", tag});
            push(c0 + G - 1, s0, 1, 0, 0, m_frz, 0, {"R4 no early step ", tag});
            push(c0 + G, s1, 1, 0, 0, m_frz, 0, {"R3 thaw step1 ", tag});
            push(c0 + 2*G - 1, s1, 1, 0, 0, m_frz, 0, {"R4 no early step2 ", tag});
            m_frz[ch] = 1'b0;
            push(c0 + 2*G, s2, 0, 0, 0, m_frz, 0, {"R3/R8 thaw last ", tag});
            m_ctrl = s2;
            last = c0 + 2*G;
        end
        @(negedge clk);
        if (poke) begin
            req_valid = 1'b1; req_thaw = 1'b0; req_chan = 3'((ch + 1) % NCH);
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (cyc <= last + 1) @(negedge clk);
    endtask

    // Issue a request with an out-of-range channel index
    task automatic bad_req(input int ch);
        int c;
        @(negedge clk);
        req_valid = 1'b1; req_thaw = 1'b1; req_chan = 3'(ch);
        @(posedge clk); #1;
        c = cyc;
        push(c,     m_ctrl, 0, 0, 1, m_frz, m_src, "R6 rejected index");
        push(c + 1, m_ctrl, 0, 0, 0, m_frz, m_src, "R6 no effect after");
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(cyc + 1, '0, 0, 0, 0, '1, 1, "R1 reset state");
        @(negedge clk); @(negedge clk);
        bad_req(3);
        bad_req(7);
        run_seq(1'b0, 1, "R9 freeze already frozen ch1", 1'b0);
        run_seq(1'b1, 0, "thaw ch0", 1'b0);
        run_seq(1'b1, 0, "R9 thaw already thawed ch0", 1'b0);
        run_seq(1'b1, 2, "thaw ch2 with poke", 1'b1);
        run_seq(1'b0, 0, "freeze ch0", 1'b0);
        run_seq(1'b1, 1, "thaw ch1 with poke", 1'b1);
        run_seq(1'b0, 2, "freeze ch2", 1'b1);
        bad_req(5);
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL R7 scoreboard leftover actual=%0d expected=0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++; n_err++;
        $display("FAIL R7 watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule